// File: doc/BRIEF.md
# Heartbeat Watchdog with Latched Shutdown

This block watches a controller through a single heartbeat bit. The heartbeat is the lowest bit of a down-counter. A fast, servo-rate tick pulse decrements the counter, and a slower background-done pulse reloads it from a programmable value. The counter stops at zero. If either task stalls, the counter stops changing, so the heartbeat stops toggling. A tick that never arrives freezes the value. A reload that never arrives lets the counter run down to zero and hold there.

A monitor passes the heartbeat through a two-flop synchronizer and detects both rising and falling edges. It also times the gap between edges against a timeout set in clock cycles. The timeout is the digital form of a minimum heartbeat frequency, about 25 Hz in a typical system. The monitor also watches a digital supply-good input. When the gap runs out, or when the supply-good input goes low, the block latches a trip. While tripped, the block:
- holds every peripheral reset asserted,
- gates all discrete output enables and all proportional output enables to zero,
- raises a trip flag, which can be used to drop amplifier power.

Only the active-low init line `rst_n` clears the trip. There is no streaming data path. Every pin is a plain level or one-cycle pulse, with no valid/ready handshake and no back-pressure.

Top module: `hb_watchdog`

## Requirements
- R1: On a clock edge with `servo_tick` high and `bg_done` low, the counter decrements by one if it is non-zero. If it is zero, it stays at zero and does not wrap.
- R2: Output `heartbeat` equals bit 0 of the counter and changes on the clock edge that updates the counter.
- R3: On a clock edge with `bg_done` high, the counter loads the reload value, even if `servo_tick` is high in the same cycle. After reset the counter holds `DEFAULT_RELOAD` (4096), so `heartbeat` is 0.
- R4: A `reload_cfg` value of 0 loads `DEFAULT_RELOAD` (4096) instead of 0.
- R5: Rising and falling heartbeat edges both restart an interval timer. If `TIMEOUT_CYC` cycles pass with no edge, `tripped` goes high on the next edge.
- R6: When `supply_ok` is low, `tripped` goes high on the third clock edge, after a two-flop synchronizer. A one-cycle low pulse is enough.
- R7: Once `tripped` is high, it stays high whatever happens on `servo_tick`, `bg_done` or `supply_ok`.
- R8: While tripped, `disc_en_out` and `prop_en_out` are all zero and every `periph_rst` bit is 1. While not tripped, `disc_en_out` equals `disc_en_in`, `prop_en_out` equals `prop_en_in`, and `periph_rst` is all zero.
- R9: Output `tripped` is low from reset until a trip condition occurs.
- R10: Only `rst_n` low clears the trip. After `rst_n` is released, the interval timer starts again from zero, so the first heartbeat edge gets a full timeout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low init line, asynchronous assert; the only way to clear a trip |
| servo_tick | input | 1 | One-cycle servo-rate pulse that decrements the counter |
| bg_done | input | 1 | One-cycle pulse at the end of each background cycle that reloads the counter |
| reload_cfg | input | RELOAD_W | Reload value; 0 selects DEFAULT_RELOAD |
| supply_ok | input | 1 | Supply-good level; low means undervoltage |
| disc_en_in | input | N_DISC | Discrete output enables requested by the controller |
| prop_en_in | input | N_PROP | Proportional output enables requested by the controller |
| heartbeat | output | 1 | Counter bit 0 |
| tripped | output | 1 | Latched trip flag |
| periph_rst | output | N_PERIPH | Active-high resets to downstream peripheral blocks |
| disc_en_out | output | N_DISC | Gated discrete output enables |
| prop_en_out | output | N_PROP | Gated proportional output enables |

## Verification
The main function is tried with these stimulus patterns, each of which separates a healthy heartbeat from a dead one:
- Fast ticks with regular reloads. The heartbeat must keep the block alive.
- Ticks spaced just inside the timeout and just outside it. These separate the pass and fail sides of the interval check.
- A reload that arrives once and never again. The counter runs to zero and must hold there, not wrap.
- Reloads that arrive with no ticks at all. The value freezes.
- A reload value of zero. If zero were loaded literally instead of being replaced by 4096, the block would trip.

Directed cases cover:
- stepping the heartbeat bit,
- a tick and a reload arriving together,
- a one-cycle supply glitch,
- heartbeat activity after a trip,
- the restart of the interval window after the init line is released.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;
  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_TRIP = 1'b1
  } wd_state_e;

  // Picks the effective reload: a zero setting maps to the default count.
  function automatic logic [31:0] pick_reload(input logic [31:0] cfg,
                                              input logic [31:0] dflt);
    return (cfg == 32'd0) ? dflt : cfg;
  endfunction
endpackage

// File: rtl/hb_counter.sv
module hb_counter #(
  parameter int RELOAD_W       = 16,
  parameter int DEFAULT_RELOAD = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                servo_tick,
  input  logic                bg_done,
  input  logic [RELOAD_W-1:0] reload_cfg,
  output logic                hb
);
  import hbwd_pkg::*;

  localparam int CNT_W = RELOAD_W;
  localparam logic [CNT_W-1:0] DFLT = CNT_W'(DEFAULT_RELOAD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic [31:0]      picked;

  assign picked   = pick_reload(32'(reload_cfg), 32'(DFLT));
  assign load_val = picked[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= DFLT;
    end else if (bg_done) begin
      cnt <= load_val;
    end else if (servo_tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign hb = cnt[0];

  assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (servo_tick && !bg_done && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_floor_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (servo_tick && !bg_done && cnt == '0) |=> (cnt == '0));

  assert_reload_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bg_done |=> (cnt != '0));

  assert_zero_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_done && reload_cfg == '0) |=> (cnt == DFLT));
endmodule

// File: rtl/hb_monitor.sv
module hb_monitor #(
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_raw,
  input  logic supply_ok,
  output logic stall,
  output logic undervolt
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] LIMIT = TMR_W'(TIMEOUT_CYC);

  logic       hb_s1, hb_s2, hb_s3;
  logic       sup_s1, sup_s2;
  logic       hb_edge;
  logic [TMR_W-1:0] gap_tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_s1 <= 1'b0;
      hb_s2 <= 1'b0;
      hb_s3 <= 1'b0;
    end else begin
      hb_s1 <= hb_raw;
      hb_s2 <= hb_s1;
      hb_s3 <= hb_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_s1 <= 1'b1;
      sup_s2 <= 1'b1;
    end else begin
      sup_s1 <= supply_ok;
      sup_s2 <= sup_s1;
    end
  end

  assign hb_edge = hb_s2 ^ hb_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_tmr <= '0;
    end else if (hb_edge) begin
      gap_tmr <= '0;
    end else if (gap_tmr != LIMIT) begin
      gap_tmr <= gap_tmr + 1'b1;
    end
  end

  assign stall     = (gap_tmr == LIMIT);
  assign undervolt = ~sup_s2;

  assert_edge_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hb_edge |=> !stall);

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_s1) |=> undervolt);
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  input  logic undervolt,
  output logic tripped
);
  import hbwd_pkg::*;

  wd_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WD_RUN;
    end else if (stall || undervolt) begin
      state <= WD_TRIP;
    end
  end

  assign tripped = (state == WD_TRIP);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |=> tripped);

  assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> ($past(stall) || $past(undervolt)));
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int RELOAD_W       = 16,
  parameter int DEFAULT_RELOAD = 4096,
  parameter int TIMEOUT_CYC    = 2000000,
  parameter int N_DISC         = 8,
  parameter int N_PROP         = 4,
  parameter int N_PERIPH       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                servo_tick,
  input  logic                bg_done,
  input  logic [RELOAD_W-1:0] reload_cfg,
  input  logic                supply_ok,
  input  logic [N_DISC-1:0]   disc_en_in,
  input  logic [N_PROP-1:0]   prop_en_in,
  output logic                heartbeat,
  output logic                tripped,
  output logic [N_PERIPH-1:0] periph_rst,
  output logic [N_DISC-1:0]   disc_en_out,
  output logic [N_PROP-1:0]   prop_en_out
);
  logic hb_int;
  logic stall;
  logic undervolt;
  logic trip_int;

  hb_counter #(
    .RELOAD_W       (RELOAD_W),
    .DEFAULT_RELOAD (DEFAULT_RELOAD)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .servo_tick (servo_tick),
    .bg_done    (bg_done),
    .reload_cfg (reload_cfg),
    .hb         (hb_int)
  );

  hb_monitor #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .hb_raw    (hb_int),
    .supply_ok (supply_ok),
    .stall     (stall),
    .undervolt (undervolt)
  );

  trip_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .undervolt (undervolt),
    .tripped   (trip_int)
  );

  assign heartbeat = hb_int;
  assign tripped   = trip_int;

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_prst
    assign periph_rst[p] = trip_int;
  end

  for (genvar d = 0; d < N_DISC; d++) begin : g_disc
    assign disc_en_out[d] = disc_en_in[d] & ~trip_int;
  end

  for (genvar q = 0; q < N_PROP; q++) begin : g_prop
    assign prop_en_out[q] = prop_en_in[q] & ~trip_int;
  end

  assert_stall_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> tripped);

  assert_uv_trips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    undervolt |=> tripped);

  assert_outputs_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (disc_en_out == '0 && prop_en_out == '0 && (&periph_rst)));
endmodule

// File: tb/test_hb_watchdog.sv
module test_hb_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int RW         = 16;
  localparam int ND         = 8;
  localparam int NP         = 4;
  localparam int NR         = 4;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    int unsigned tick_p;   // 0 = never tick
    int unsigned bg_p;     // 0 = one reload at start only
    logic [15:0] reload;
    logic        supply;
    int unsigned cycles;
    logic        exp_trip;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{tick_p: 10, bg_p: 50, reload: 16'd20, supply: 1'b1, cycles: 300, exp_trip: 1'b0},
    '{tick_p: 60, bg_p: 50, reload: 16'd20, supply: 1'b1, cycles: 300, exp_trip: 1'b1},
    '{tick_p: 10, bg_p: 0,  reload: 16'd5,  supply: 1'b1, cycles: 300, exp_trip: 1'b1},
    '{tick_p: 10, bg_p: 50, reload: 16'd0,  supply: 1'b1, cycles: 300, exp_trip: 1'b0},
    '{tick_p: 30, bg_p: 0,  reload: 16'd0,  supply: 1'b1, cycles: 300, exp_trip: 1'b0},
    '{tick_p: 45, bg_p: 0,  reload: 16'd0,  supply: 1'b1, cycles: 300, exp_trip: 1'b1},
    '{tick_p: 10, bg_p: 50, reload: 16'd20, supply: 1'b0, cycles: 300, exp_trip: 1'b1},
    '{tick_p: 0,  bg_p: 50, reload: 16'd20, supply: 1'b1, cycles: 300, exp_trip: 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          servo_tick = 1'b0;
  logic          bg_done = 1'b0;
  logic [RW-1:0] reload_cfg = '0;
  logic          supply_ok = 1'b1;
  logic [ND-1:0] disc_en_in = '1;
  logic [NP-1:0] prop_en_in = '1;
  logic          heartbeat;
  logic          tripped;
  logic [NR-1:0] periph_rst;
  logic [ND-1:0] disc_en_out;
  logic [NP-1:0] prop_en_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  hb_watchdog #(
    .RELOAD_W       (RW),
    .DEFAULT_RELOAD (4096),
    .TIMEOUT_CYC    (TMO),
    .N_DISC         (ND),
    .N_PROP         (NP),
    .N_PERIPH       (NR)
  ) i_hb_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .servo_tick  (servo_tick),
    .bg_done     (bg_done),
    .reload_cfg  (reload_cfg),
    .supply_ok   (supply_ok),
    .disc_en_in  (disc_en_in),
    .prop_en_in  (prop_en_in),
    .heartbeat   (heartbeat),
    .tripped     (tripped),
    .periph_rst  (periph_rst),
    .disc_en_out (disc_en_out),
    .prop_en_out (prop_en_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n      = 1'b0;
    servo_tick = 1'b0;
    bg_done    = 1'b0;
    supply_ok  = 1'b1;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic tk, input logic bg);
    servo_tick = tk;
    bg_done    = bg;
    step(1);
    servo_tick = 1'b0;
    bg_done    = 1'b0;
  endtask

  task automatic chk_gating(input string req);
    if (tripped) begin
      chk(disc_en_out == '0 && prop_en_out == '0 && periph_rst == '1, req,
          {disc_en_out, prop_en_out, periph_rst}, {ND'(0), NP'(0), {NR{1'b1}}});
    end else begin
      chk(disc_en_out == disc_en_in && prop_en_out == prop_en_in && periph_rst == '0,
          req, {disc_en_out, prop_en_out, periph_rst},
          {disc_en_in, prop_en_in, NR'(0)});
    end
  endtask

  initial begin
    // Reset state (R9, R3, R8)
    do_reset();
    step(1);
    chk(tripped == 1'b0, "R9 reset tripped", 32'(tripped), 0);
    chk(heartbeat == 1'b0, "R3 reset count 4096", 32'(heartbeat), 0);
    disc_en_in = 8'hA5;
    prop_en_in = 4'h6;
    step(1);
    chk_gating("R8 pass-through");
    disc_en_in = '1;
    prop_en_in = '1;

    // Table walk: R1 R4 R5 R6 R8
    for (int r = 0; r < NROWS; r++) begin
      do_reset();
      reload_cfg = ROWS[r].reload;
      supply_ok  = ROWS[r].supply;
      for (int c = 0; c < int'(ROWS[r].cycles); c++) begin
        servo_tick = (ROWS[r].tick_p != 0) &&
                     ((c % int'(ROWS[r].tick_p)) == int'(ROWS[r].tick_p) - 1);
        bg_done    = (ROWS[r].bg_p == 0) ? (c == 0) :
                     ((c % int'(ROWS[r].bg_p)) == 0);
        step(1);
      end
      servo_tick = 1'b0;
      bg_done    = 1'b0;
      chk(tripped == ROWS[r].exp_trip, $sformatf("R5/R6 table row %0d", r),
          32'(tripped), 32'(ROWS[r].exp_trip));
      chk_gating($sformatf("R8 table row %0d", r));
    end

    // Counter stepping: R1 R2 R3 R4
    do_reset();
    reload_cfg = 16'd3;
    pulse(1'b0, 1'b1);
    chk(heartbeat == 1'b1, "R3 reload 3", 32'(heartbeat), 1);
    pulse(1'b1, 1'b0);
    chk(heartbeat == 1'b0, "R2 tick to 2", 32'(heartbeat), 0);
    pulse(1'b1, 1'b0);
    chk(heartbeat == 1'b1, "R1 tick to 1", 32'(heartbeat), 1);
    reload_cfg = 16'd1;
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    chk(heartbeat == 1'b0, "R1 reach zero", 32'(heartbeat), 0);
    pulse(1'b1, 1'b0);
    chk(heartbeat == 1'b0, "R1 hold at zero", 32'(heartbeat), 0);
    reload_cfg = 16'd0;
    pulse(1'b0, 1'b1);
    chk(heartbeat == 1'b0, "R4 zero cfg even", 32'(heartbeat), 0);
    pulse(1'b1, 1'b0);
    chk(heartbeat == 1'b1, "R4 4096 minus 1", 32'(heartbeat), 1);
    reload_cfg = 16'd3;
    pulse(1'b1, 1'b1);
    chk(heartbeat == 1'b1, "R3 reload beats tick", 32'(heartbeat), 1);

    // Supply glitch: R6 latency and R7 latch
    do_reset();
    step(5);
    supply_ok = 1'b0;
    step(1);
    supply_ok = 1'b1;
    step(1);
    chk(tripped == 1'b0, "R6 before sync delay", 32'(tripped), 0);
    step(1);
    chk(tripped == 1'b1, "R6 glitch trips", 32'(tripped), 1);
    step(10);
    chk(tripped == 1'b1, "R7 supply restored", 32'(tripped), 1);

    // Heartbeat after a stall trip: R7
    do_reset();
    reload_cfg = 16'd20;
    step(TMO + 10);
    chk(tripped == 1'b1, "R5 no heartbeat", 32'(tripped), 1);
    for (int c = 0; c < 100; c++) begin
      servo_tick = (c % 5) == 4;
      bg_done    = (c % 50) == 0;
      step(1);
    end
    servo_tick = 1'b0;
    bg_done    = 1'b0;
    chk(tripped == 1'b1, "R7 heartbeat resumed", 32'(tripped), 1);
    chk_gating("R8 while latched");

    // Clear by init line and window restart: R10
    do_reset();
    step(1);
    chk(tripped == 1'b0, "R10 init clears", 32'(tripped), 0);
    step(TMO - 8);
    chk(tripped == 1'b0, "R10 full window", 32'(tripped), 0);
    step(20);
    chk(tripped == 1'b1, "R10 window expires", 32'(tripped), 1);

    finish_run();
  end
endmodule